// File: doc/BRIEF.md
# Register-Mapped SPI Master

This block is a serial peripheral interface master that a processor drives through three word registers on a simple word-addressed bus: a control register, a status register and a data register. Software picks the clock polarity and phase, the bit order (most or least significant first), the frame width (8 or 16 bits) and a 3-bit clock divider. It then writes words to the data register and reads received words back from the same address. The block drives the serial clock, the serial data output and a chip-select line, and samples the serial data input.

One transmit holding register sits in front of the shift register. The transmit-empty flag rises as soon as the first clock edge of a frame has passed. Software that refills the holding register before the current frame ends gets a continuous stream with no idle clock period between frames. A frame is clocked only when the holding register has a word in it, so a pure read needs a dummy write. A receive-only mode is the exception: it clocks frames by itself while the receive buffer is empty. A single receive buffer with a not-empty flag collects each finished frame.

Top module: `spi_master_regs`

## Requirements
- R1: After reset the status register reads 0x0002 (TBE set, RBNE and TRANS clear), the control register reads 0, SCK is low and chip-select is high.
- R2: Bus addresses are 0 for control, 1 for status and 2 for data. Read data appears on `bus_rdata` one cycle after the read request. Control bits 15:12 always read 0.
- R3: Control bit 0 is the phase and bit 1 the polarity. SCK idles at the polarity level. With phase 0 each bit is sampled on the first edge of its clock period, and with phase 1 on the second.
- R4: Control bit 7 set sends and receives least significant bit first, clear sends most significant bit first. Control bit 11 selects a 16-bit frame when set and an 8-bit frame (bits 7:0) when clear.
- R5: Prescaler code n in control bits 5:3 makes each SCK half period 2^n bus clocks, so a lone frame of W bits keeps TRANS high for exactly 2·W·2^n cycles.
- R6: A data write clears TBE (status bit 1). TBE is set again at the first SCK edge of the frame that took the word.
- R7: If the data register is written again before the running frame ends, the next frame follows with no idle SCK period, and TRANS (status bit 7) stays high across both frames.
- R8: At the end of each frame the received word goes to the receive buffer and RBNE (status bit 0) is set. Reading the data register returns that word (upper byte 0 in 8-bit frames) and clears RBNE.
- R9: A data write is ignored unless enable (control bit 6) and master (control bit 2) are both set. No frame starts while the transmit holding register is empty.
- R10: With receive-only (control bit 10) set, frames run with MOSI held low whenever the receive buffer is empty at a frame boundary.
- R11: Clearing enable aborts a running frame: TRANS drops, SCK returns to its idle level, and RBNE keeps its value.
- R12: With control bit 9 set, chip-select follows control bit 8. Otherwise it is low while a frame runs and high when idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and logic clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 1 | Chip-select, active low |

## Verification
A wrong edge counter or a wrong divider shows up within one frame. The number of captured bits, the length of the chip-select low window, or the looped-back word comes out wrong. Broken sample or shift selection shows up as a corrupted or bit-reversed word on the first frame of the affected mode. A TBE or holding-register flag that is stuck or set late shows up two ways: a stalled stream, or a second chip-select rising edge within the gapless test. An abort that leaves state behind leaves TRANS set or SCK off its idle level two cycles after enable is cleared.

// File: rtl/spi_regs_pkg.sv
package spi_regs_pkg;
  localparam int WORD_W = 16;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_DATA = 2'd2;

  localparam int STAT_RBNE  = 0;
  localparam int STAT_TBE   = 1;
  localparam int STAT_TRANS = 7;

  // field positions are decoded by software, so they are fixed
  typedef struct packed {
    logic [3:0] rsvd;
    logic       wide;
    logic       rx_only;
    logic       cs_sw_en;
    logic       cs_sw_lvl;
    logic       lsb_first;
    logic       enable;
    logic [2:0] div_code;
    logic       master;
    logic       cpol;
    logic       cpha;
  } ctrl_t;
endpackage

// File: rtl/spi_prescaler.sv
module spi_prescaler #(
  parameter  int CODE_W = 3,
  localparam int CNT_W  = (1 << CODE_W) - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [CODE_W-1:0] code,
  output logic              tick
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;

  // half period of 2^code cycles: count 0 .. 2^code-1
  assign limit = CNT_W'((32'd1 << code) - 32'd1);
  assign tick  = run && (cnt == limit);

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
  parameter  int DATA_W = 16,
  localparam int HALF_W = DATA_W / 2,
  localparam int EDGE_W = $clog2(2 * DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              lsb_first,
  input  logic              wide,
  input  logic              rx_only,
  input  logic              tick,
  input  logic              tx_pend,
  input  logic              rx_full,
  input  logic [DATA_W-1:0] tx_word,
  input  logic              miso,
  output logic              busy,
  output logic              load,
  output logic              first_edge,
  output logic              done,
  output logic              sck,
  output logic              mosi,
  output logic [DATA_W-1:0] rx_word
);
  logic [EDGE_W-1:0] edge_idx;
  logic [EDGE_W-1:0] last_edge;
  logic [DATA_W-1:0] tx_sh, rx_sh, rx_next, rx_fin, fresh, ld_sh;
  logic              start_ok, at_last, sample_now, present_now, ld_mosi;

  function automatic logic out_bit(input logic [DATA_W-1:0] v, input logic lsb, input logic w);
    if (lsb) return v[0];
    return w ? v[DATA_W-1] : v[HALF_W-1];
  endfunction

  function automatic logic [DATA_W-1:0] advance(input logic [DATA_W-1:0] v, input logic lsb);
    return lsb ? (v >> 1) : (v << 1);
  endfunction

  assign last_edge   = wide ? EDGE_W'(2 * DATA_W - 1) : EDGE_W'(2 * HALF_W - 1);
  assign start_ok    = en && (rx_only ? !rx_full : tx_pend);
  assign at_last     = busy && tick && (edge_idx == last_edge);
  assign first_edge  = busy && tick && (edge_idx == '0);
  assign done        = at_last;
  assign load        = start_ok && (!busy || at_last);
  // phase 0: sample even edges, present on odd; phase 1: present even, sample odd
  assign sample_now  = cpha ? edge_idx[0] : !edge_idx[0];
  assign present_now = cpha ? !edge_idx[0] : edge_idx[0];
  assign fresh       = rx_only ? '0 : tx_word;
  // phase 0 puts the first bit out at load time, phase 1 waits for edge 0
  assign ld_sh       = cpha ? fresh : advance(fresh, lsb_first);
  assign ld_mosi     = cpha ? mosi  : out_bit(fresh, lsb_first, wide);

  always_comb begin
    rx_next = lsb_first ? (rx_sh >> 1) : (rx_sh << 1);
    if (lsb_first) begin
      if (wide) rx_next[DATA_W-1] = miso;
      else      rx_next[HALF_W-1] = miso;
    end else begin
      rx_next[0] = miso;
    end
    rx_fin  = sample_now ? rx_next : rx_sh;
    rx_word = wide ? rx_fin : {{(DATA_W-HALF_W){1'b0}}, rx_fin[HALF_W-1:0]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      edge_idx <= '0;
      sck      <= 1'b0;
      mosi     <= 1'b0;
      tx_sh    <= '0;
      rx_sh    <= '0;
    end else if (!en) begin
      busy     <= 1'b0;
      edge_idx <= '0;
      sck      <= cpol;
    end else if (!busy) begin
      sck <= cpol;
      if (load) begin
        busy     <= 1'b1;
        edge_idx <= '0;
        tx_sh    <= ld_sh;
        mosi     <= ld_mosi;
      end
    end else if (tick) begin
      sck <= ~sck;
      if (sample_now) rx_sh <= rx_next;
      if (at_last) begin
        edge_idx <= '0;
        if (load) begin
          tx_sh <= ld_sh;
          mosi  <= ld_mosi;
        end else begin
          busy <= 1'b0;
        end
      end else begin
        edge_idx <= edge_idx + 1'b1;
        if (present_now) begin
          mosi  <= out_bit(tx_sh, lsb_first, wide);
          tx_sh <= advance(tx_sh, lsb_first);
        end
      end
    end
  end
endmodule

// File: rtl/spi_master_regs.sv
module spi_master_regs
  import spi_regs_pkg::*;
#(
  parameter  int DATA_W = WORD_W,
  parameter  int CODE_W = 3,
  localparam int AW     = ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              spi_sck,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic              spi_cs_n
);
  ctrl_t             ctrl_q;
  logic [DATA_W-1:0] tx_buf, rx_buf, stat_w, rx_word;
  logic              tx_pend, tbe_q, rbne_q;
  logic              busy, load, first_edge, done, tick, eng_en;
  logic              wr_ctrl, wr_data, rd_data;

  assign eng_en  = ctrl_q.enable && ctrl_q.master;
  assign wr_ctrl = bus_sel && bus_wr && (bus_addr == ADDR_CTRL);
  assign wr_data = bus_sel && bus_wr && (bus_addr == ADDR_DATA) && eng_en;
  assign rd_data = bus_sel && !bus_wr && (bus_addr == ADDR_DATA);

  spi_prescaler #(.CODE_W(CODE_W)) u_div (
    .clk  (clk),
    .rst  (rst),
    .run  (busy),
    .code (ctrl_q.div_code),
    .tick (tick)
  );

  spi_shift_engine #(.DATA_W(DATA_W)) u_eng (
    .clk        (clk),
    .rst        (rst),
    .en         (eng_en),
    .cpol       (ctrl_q.cpol),
    .cpha       (ctrl_q.cpha),
    .lsb_first  (ctrl_q.lsb_first),
    .wide       (ctrl_q.wide),
    .rx_only    (ctrl_q.rx_only),
    .tick       (tick),
    .tx_pend    (tx_pend),
    .rx_full    (rbne_q),
    .tx_word    (tx_buf),
    .miso       (spi_miso),
    .busy       (busy),
    .load       (load),
    .first_edge (first_edge),
    .done       (done),
    .sck        (spi_sck),
    .mosi       (spi_mosi),
    .rx_word    (rx_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (wr_ctrl) begin
      ctrl_q      <= ctrl_t'(bus_wdata);
      ctrl_q.rsvd <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_buf  <= '0;
      tx_pend <= 1'b0;
      tbe_q   <= 1'b1;
    end else if (wr_data) begin
      tx_buf  <= bus_wdata;
      tx_pend <= 1'b1;
      tbe_q   <= 1'b0;
    end else begin
      if (load && !ctrl_q.rx_only) tx_pend <= 1'b0;
      if (first_edge)              tbe_q   <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_buf <= '0;
      rbne_q <= 1'b0;
    end else if (done) begin
      rx_buf <= rx_word;
      rbne_q <= 1'b1;
    end else if (rd_data) begin
      rbne_q <= 1'b0;
    end
  end

  always_comb begin
    stat_w             = '0;
    stat_w[STAT_RBNE]  = rbne_q;
    stat_w[STAT_TBE]   = tbe_q;
    stat_w[STAT_TRANS] = busy;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_sel && !bus_wr) begin
      case (bus_addr)
        ADDR_CTRL: bus_rdata <= DATA_W'(ctrl_q);
        ADDR_STAT: bus_rdata <= stat_w;
        ADDR_DATA: bus_rdata <= rx_buf;
        default:   bus_rdata <= '0;
      endcase
    end
  end

  assign spi_cs_n = ctrl_q.cs_sw_en ? ctrl_q.cs_sw_lvl : !busy;
endmodule

// File: rtl/spi_master_chk.sv
module spi_master_chk (
  input logic       clk,
  input logic       rst,
  input logic       sck,
  input logic       cpol,
  input logic       busy,
  input logic       en_master,
  input logic       tbe,
  input logic       rbne,
  input logic       bus_sel,
  input logic       bus_wr,
  input logic [1:0] bus_addr
);
  a_r3_idle_level: assert property (@(posedge clk) disable iff (rst)
    (!busy && $past(!busy) && $stable(cpol)) |-> (sck == cpol));

  a_r11_abort_stops: assert property (@(posedge clk) disable iff (rst)
    !en_master |=> !busy);

  a_r6_tbe_cleared_by_write: assert property (@(posedge clk) disable iff (rst)
    $fell(tbe) |-> $past(bus_sel && bus_wr && bus_addr == 2'd2));

  a_r8_rbne_after_frame: assert property (@(posedge clk) disable iff (rst)
    $rose(rbne) |-> $past(busy));

  a_r9_start_needs_enable: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(en_master));
endmodule

bind spi_master_regs spi_master_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .sck       (spi_sck),
  .cpol      (ctrl_q.cpol),
  .busy      (busy),
  .en_master (eng_en),
  .tbe       (tbe_q),
  .rbne      (rbne_q),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr)
);

// File: tb/spi_master_regs_test.sv
module spi_master_regs_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [15:0] bus_wdata = 16'h0;
  logic [15:0] bus_rdata;
  logic        spi_sck, spi_mosi, spi_cs_n;
  logic        loop_en = 1'b1;
  logic        spi_miso;

  int checks = 0, errors = 0;

  always #2 clk = ~clk;
  assign spi_miso = loop_en ? spi_mosi : 1'b1;

  spi_master_regs uut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sck(spi_sck),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
  );

  // serial-side monitor
  logic        prev_sck = 1'b0, prev_cs = 1'b1;
  logic        tb_cpol = 1'b0, tb_cpha = 1'b0;
  logic [15:0] cap = 16'h0;
  int          cap_n = 0, low_cnt = 0, cs_rise = 0;

  always @(negedge clk) begin
    if (spi_sck !== prev_sck && spi_sck == (tb_cpol ^ ~tb_cpha)) begin
      cap   = {cap[14:0], spi_mosi};
      cap_n = cap_n + 1;
    end
    prev_sck = spi_sck;
    if (!spi_cs_n) low_cnt = low_cnt + 1;
    if (spi_cs_n && !prev_cs) cs_rise = cs_rise + 1;
    prev_cs = spi_cs_n;
  end

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] mk_ctrl(input logic cpha, input logic cpol, input logic mst,
      input logic [2:0] dv, input logic en, input logic lsb, input logic cs_lvl,
      input logic cs_en, input logic ro, input logic wide);
    return {4'h0, wide, ro, cs_en, cs_lvl, lsb, en, dv, mst, cpol, cpha};
  endfunction

  function automatic logic [15:0] rev_bits(input logic [15:0] v, input logic wide);
    logic [15:0] r = 16'h0;
    int w = wide ? 16 : 8;
    for (int i = 0; i < w; i++) r[w-1-i] = v[i];
    return r;
  endfunction

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wait_idle(input string req);
    logic [15:0] s;
    for (int i = 0; i < 3000; i++) begin
      rd(2'd1, s);
      if (!s[7]) return;
    end
    check(req, "frame never ended", 32'd1, 32'd0);
  endtask

  task automatic clear_mon();
    cap = 16'h0; cap_n = 0; low_cnt = 0; cs_rise = 0;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    rd(2'd1, d); check("R1", "status after reset", d, 16'h0002);
    rd(2'd0, d); check("R1", "control after reset", d, 16'h0000);
    check("R1", "sck after reset", spi_sck, 1'b0);
    check("R1", "cs_n after reset", spi_cs_n, 1'b1);
  endtask

  task automatic t_regmap();
    logic [15:0] d;
    wr(2'd0, 16'hF0A5);
    rd(2'd0, d); check("R2", "control readback, reserved bits zero", d, 16'h00A5);
    wr(2'd0, 16'h0000);
    rd(2'd3, d); check("R2", "unused address reads zero", d, 16'h0000);
  endtask

  task automatic t_frame(input logic cpha, input logic cpol, input logic lsb,
                         input logic wide, input logic [2:0] dv, input logic [15:0] data);
    logic [15:0] d, exp;
    int w = wide ? 16 : 8;
    exp = wide ? data : {8'h00, data[7:0]};
    wr(2'd0, mk_ctrl(cpha, cpol, 1'b1, dv, 1'b1, lsb, 1'b0, 1'b0, 1'b0, wide));
    tb_cpol = cpol; tb_cpha = cpha;
    repeat (3) @(negedge clk);
    clear_mon();
    wr(2'd2, data);
    wait_idle("R3");
    check("R3", "sample edge count", cap_n, w);
    check("R4", "bit order on MOSI", lsb ? rev_bits(cap, wide) : (cap & (wide ? 16'hFFFF : 16'h00FF)), exp);
    check("R3", "sck back at idle level", spi_sck, cpol);
    rd(2'd1, d); check("R8", "RBNE after frame", d[0], 1'b1);
    rd(2'd2, d); check("R8", "looped-back word", d, exp);
    rd(2'd1, d); check("R8", "RBNE cleared by read", d[0], 1'b0);
  endtask

  task automatic t_timing(input logic [2:0] dv, input logic wide, input int exp_cycles);
    wr(2'd0, mk_ctrl(1'b0, 1'b0, 1'b1, dv, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, wide));
    tb_cpol = 1'b0; tb_cpha = 1'b0;
    repeat (3) @(negedge clk);
    clear_mon();
    wr(2'd2, 16'h5A5A);
    wait_idle("R5");
    check("R5", "cycles with frame active", low_cnt, exp_cycles);
    begin logic [15:0] d; rd(2'd2, d); end
  endtask

  task automatic t_tbe();
    logic [15:0] d;
    wr(2'd0, mk_ctrl(1'b0, 1'b0, 1'b1, 3'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0));
    repeat (3) @(negedge clk);
    wr(2'd2, 16'h0033);
    rd(2'd1, d); check("R6", "TBE cleared by write", d[1], 1'b0);
    repeat (8) @(negedge clk);
    rd(2'd1, d); check("R6", "TBE set after first edge, TRANS high", {d[7], d[1]}, 2'b11);
    wait_idle("R6");
    rd(2'd2, d);
  endtask

  task automatic t_gapless();
    logic [15:0] d;
    bit got = 0;
    wr(2'd0, mk_ctrl(1'b0, 1'b0, 1'b1, 3'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0));
    tb_cpol = 1'b0; tb_cpha = 1'b0;
    repeat (3) @(negedge clk);
    clear_mon();
    wr(2'd2, 16'h00C6);
    for (int i = 0; i < 20 && !got; i++) begin
      rd(2'd1, d);
      if (d[1]) got = 1;
    end
    check("R7", "TBE seen during first frame", got, 1'b1);
    wr(2'd2, 16'h0019);
    wait_idle("R7");
    check("R7", "two frames without a gap", low_cnt, 64);
    check("R7", "single chip-select window", cs_rise, 1);
    check("R7", "both words streamed", cap, 16'hC619);
    rd(2'd2, d); check("R8", "last frame kept", d, 16'h0019);
  endtask

  task automatic t_gate();
    logic [15:0] d;
    wr(2'd0, mk_ctrl(1'b0, 1'b0, 1'b0, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0));
    repeat (3) @(negedge clk);
    clear_mon();
    wr(2'd2, 16'h00FF);
    repeat (20) @(negedge clk);
    rd(2'd1, d); check("R9", "write ignored without master", d, 16'h0002);
    wr(2'd0, mk_ctrl(1'b0, 1'b0, 1'b1, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0));
    wr(2'd2, 16'h00FF);
    repeat (5) @(negedge clk);
    wr(2'd0, mk_ctrl(1'b0, 1'b0, 1'b1, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0));
    repeat (20) @(negedge clk);
    rd(2'd1, d); check("R9", "no frame without data", d, 16'h0002);
    check("R9", "no sck activity", cap_n, 0);
  endtask

  task automatic t_rx_only();
    logic [15:0] d;
    bit got = 0;
    loop_en = 1'b0;
    tb_cpol = 1'b0; tb_cpha = 1'b0;
    clear_mon();
    wr(2'd0, mk_ctrl(1'b0, 1'b0, 1'b1, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0));
    for (int i = 0; i < 40 && !got; i++) begin
      rd(2'd1, d);
      if (d[0]) got = 1;
    end
    check("R10", "frame clocked without write", got, 1'b1);
    rd(2'd2, d); check("R10", "received word", d, 16'h00FF);
    check("R10", "MOSI held low", cap[7:0], 8'h00);
    wr(2'd0, 16'h0000);
    loop_en = 1'b1;
    repeat (3) @(negedge clk);
    rd(2'd2, d);
  endtask

  task automatic t_abort();
    logic [15:0] d, c;
    c = mk_ctrl(1'b0, 1'b1, 1'b1, 3'd7, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    wr(2'd0, c);
    tb_cpol = 1'b1;
    repeat (3) @(negedge clk);
    wr(2'd2, 16'hBEEF);
    repeat (300) @(negedge clk);
    rd(2'd1, d); check("R11", "frame running before abort", d[7], 1'b1);
    c[6] = 1'b0;
    wr(2'd0, c);
    repeat (2) @(negedge clk);
    check("R11", "sck at idle after abort", spi_sck, 1'b1);
    check("R11", "chip-select released", spi_cs_n, 1'b1);
    rd(2'd1, d); check("R11", "TRANS clear, RBNE kept", {d[7], d[0]}, 2'b00);
    wr(2'd0, 16'h0000);
    tb_cpol = 1'b0;
  endtask

  task automatic t_cs();
    logic [15:0] d;
    wr(2'd0, mk_ctrl(1'b0, 1'b0, 1'b1, 3'd1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0));
    repeat (2) @(negedge clk);
    check("R12", "software low level while idle", spi_cs_n, 1'b0);
    wr(2'd0, mk_ctrl(1'b0, 1'b0, 1'b1, 3'd1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0));
    wr(2'd2, 16'h0042);
    repeat (6) @(negedge clk);
    check("R12", "software high level during frame", spi_cs_n, 1'b1);
    wait_idle("R12");
    rd(2'd2, d);
    wr(2'd0, mk_ctrl(1'b0, 1'b0, 1'b1, 3'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0));
    repeat (2) @(negedge clk);
    check("R12", "hardware level high when idle", spi_cs_n, 1'b1);
    wr(2'd2, 16'h0042);
    repeat (4) @(negedge clk);
    check("R12", "hardware level low during frame", spi_cs_n, 1'b0);
    wait_idle("R12");
    rd(2'd2, d);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    t_reset();
    t_regmap();
    t_frame(1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 16'h00A5);
    t_frame(1'b1, 1'b0, 1'b1, 1'b0, 3'd1, 16'h0037);
    t_frame(1'b0, 1'b1, 1'b0, 1'b1, 3'd0, 16'hC3A1);
    t_frame(1'b1, 1'b1, 1'b1, 1'b1, 3'd2, 16'h8E15);
    t_timing(3'd1, 1'b0, 32);
    t_timing(3'd3, 1'b0, 128);
    t_timing(3'd0, 1'b1, 32);
    t_tbe();
    t_gapless();
    t_gate();
    t_rx_only();
    t_abort();
    t_cs();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule